// File: doc/BRIEF.md
# External Interrupt Flag Register

This block turns eight external interrupt pins into eight sticky request flags. Each pin is brought into the clock domain by a two-stage synchronizer. It is then compared against a per-channel two-bit sense code, which selects low level, falling edge, rising edge or either edge. A match sets the channel's flag. The flag stays set until software or an exception acknowledge clears it.

Software sees the eight flags as one 8-bit status word. A flag is cleared by software only through a handshake: a read strobe must first return the flag as 1, and a later write must carry 0 in that bit. Writing 1 does nothing. A write of 0 to a flag that was never read as 1 also does nothing.

Hardware clears a flag when the CPU acknowledges that channel's exception. In low-level mode this happens only while the synchronized pin is high. A per-channel hold input blocks the acknowledge clear, so software must clear the flag. Each flag is masked by a per-channel enable to form a request output, and one global output combines all eight requests.

Top module: `ext_irq_flags`

## Requirements
- R1: Channel n uses sense code sense_i[2n+1:2n] = {b,a}. 00 selects low level, 01 falling edge, 10 rising edge and 11 both edges. Flag n is bit n of rd_data_o.
- R2: A pin edge or level that matches the channel's code sets the flag. A pin that does not match leaves the flag at 0.
- R3: After reset all flags, all request outputs and irq_any_o are 0.
- R4: Writing 1 to a set flag has no effect, even after that flag has been read as 1.
- R5: A write of 0 clears flag n only if a read strobe returned bit n as 1 earlier, after the flag last became set. Without that read the flag stays set.
- R6: In low-level mode the flag stays set while the synchronized pin is low, even if an acknowledge arrives. An acknowledge clears it once the pin is high.
- R7: In any edge mode, ack_i[n] clears flag n on the next clock edge.
- R8: While hold_i[n] is 1, ack_i[n] leaves flag n set, and the software read-then-write-0 clear still works.
- R9: irq_req_o[n] is flag n AND irq_en_i[n]. irq_any_o is 1 when any irq_req_o bit is 1.
- R10: When a set condition and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: A pin change is seen in the flag on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 8 | Asynchronous interrupt pins |
| sense_i | input | 16 | Per-channel sense code, two bits per channel |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | 8 | Flag status word |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Write data; a 0 bit requests a clear |
| ack_i | input | 8 | Per-channel exception acknowledge |
| hold_i | input | 8 | Per-channel block of the acknowledge clear |
| irq_en_i | input | 8 | Per-channel request enable |
| irq_req_o | output | 8 | Masked per-channel requests |
| irq_any_o | output | 1 | OR of all requests |

## Verification
The assertions check four things on every cycle. A flag rises only after a set condition. It falls only after an armed zero write or an unblocked acknowledge. A held or one-written flag survives the next edge. In low-level mode a low synchronized pin is always followed by a set flag.

Other behaviours are shown only by the bench's scenarios. These are the exact synchronizer latency, the decode of each sense code, the need for a prior read before a clear, and the result when a set and a clear land in the same cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned N    = 8,
  parameter bit          IDLE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  for (genvar n = 0; n < N; n++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    // reset to idle level so no edge appears at reset release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= IDLE;
        s2_q <= IDLE;
        s3_q <= IDLE;
      end else begin
        s1_q <= pin_i[n];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign cur_o[n]  = s2_q;
    assign prev_o[n] = s3_q;
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned N  = 8,
  localparam int unsigned SW = 2 * N
) (
  input  logic [SW-1:0] sense_i,
  input  logic [N-1:0]  cur_i,
  input  logic [N-1:0]  prev_i,
  output logic [N-1:0]  set_o,
  output logic [N-1:0]  ack_ok_o
);
  for (genvar n = 0; n < N; n++) begin : g_ch
    sense_e mode;
    assign mode = sense_e'(sense_i[2*n +: 2]);
    always_comb begin
      unique case (mode)
        SENSE_LOW:  set_o[n] = ~cur_i[n];
        SENSE_FALL: set_o[n] = prev_i[n] & ~cur_i[n];
        SENSE_RISE: set_o[n] = ~prev_i[n] & cur_i[n];
        default:    set_o[n] = prev_i[n] ^ cur_i[n];
      endcase
      // level mode: acknowledge only clears once the line is released
      ack_ok_o[n] = (mode != SENSE_LOW) | cur_i[n];
    end
  end
endmodule

// File: rtl/ext_irq_flag_bank.sv
module ext_irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_ok_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] hold_i,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d, armed_q, armed_d, sw_clr, hw_clr;

  always_comb begin
    sw_clr  = {N{wr_en_i}} & ~wr_data_i & armed_q;
    hw_clr  = ack_i & ~hold_i & ack_ok_i;
    // set wins over any clear in the same cycle
    flag_d  = set_i | (flag_q & ~(sw_clr | hw_clr));
    armed_d = flag_d & (armed_q | ({N{rd_en_i}} & flag_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  for (genvar n = 0; n < N; n++) begin : g_chk
    p_rise_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[n]) |-> $past(set_i[n]));
    p_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q[n]) |->
        $past((wr_en_i && !wr_data_i[n] && armed_q[n]) || (ack_i[n] && !hold_i[n])));
    p_hold_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[n] && hold_i[n] && !(wr_en_i && !wr_data_i[n])) |=> flag_q[n]);
    p_one_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[n] && !ack_i[n] && wr_en_i && wr_data_i[n]) |=> flag_q[n]);
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
  import ext_irq_pkg::*;
#(
  parameter int unsigned N  = 8,
  localparam int unsigned SW = 2 * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_pin_i,
  input  logic [SW-1:0] sense_i,
  input  logic          rd_en_i,
  output logic [N-1:0]  rd_data_o,
  input  logic          wr_en_i,
  input  logic [N-1:0]  wr_data_i,
  input  logic [N-1:0]  ack_i,
  input  logic [N-1:0]  hold_i,
  input  logic [N-1:0]  irq_en_i,
  output logic [N-1:0]  irq_req_o,
  output logic          irq_any_o
);
  logic [N-1:0] cur, prev, set, ack_ok, flag;

  ext_irq_sync #(.N(N), .IDLE(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (irq_pin_i),
    .cur_o (cur),
    .prev_o(prev)
  );

  ext_irq_sense #(.N(N)) u_sense (
    .sense_i (sense_i),
    .cur_i   (cur),
    .prev_i  (prev),
    .set_o   (set),
    .ack_ok_o(ack_ok)
  );

  ext_irq_flag_bank #(.N(N)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .ack_ok_i (ack_ok),
    .ack_i    (ack_i),
    .hold_i   (hold_i),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .flag_o   (flag)
  );

  assign rd_data_o = flag;
  assign irq_req_o = flag & irq_en_i;
  assign irq_any_o = |irq_req_o;

  p_any_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o |-> ((rd_data_o & irq_en_i) != '0));

  for (genvar n = 0; n < N; n++) begin : g_chk
    p_level_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[2*n +: 2] == SENSE_LOW && !cur[n]) |=> rd_data_o[n]);
  end
endmodule

// File: tb/ext_irq_flags_tb.sv
module ext_irq_flags_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_pin_i = 8'hFF;
  logic [15:0] sense_i = '0;
  logic        rd_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = 8'hFF;
  logic [7:0]  ack_i = '0;
  logic [7:0]  hold_i = '0;
  logic [7:0]  irq_en_i = 8'hFF;
  logic [7:0]  rd_data_o, irq_req_o;
  logic        irq_any_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ext_irq_flags u_dut (
    .clk_i, .rst_ni, .irq_pin_i, .sense_i, .rd_en_i, .rd_data_o,
    .wr_en_i, .wr_data_i, .ack_i, .hold_i, .irq_en_i, .irq_req_o, .irq_any_o
  );

  // {mode[1:0], pin_before, pin_after, expected_flag}
  localparam logic [4:0] VEC [12] = '{
    {2'b00,1'b1,1'b1,1'b0}, {2'b00,1'b1,1'b0,1'b1}, {2'b00,1'b0,1'b0,1'b1},
    {2'b01,1'b1,1'b0,1'b1}, {2'b01,1'b0,1'b1,1'b0}, {2'b01,1'b1,1'b1,1'b0},
    {2'b10,1'b0,1'b1,1'b1}, {2'b10,1'b1,1'b0,1'b0}, {2'b10,1'b0,1'b0,1'b0},
    {2'b11,1'b1,1'b0,1'b1}, {2'b11,1'b0,1'b1,1'b1}, {2'b11,1'b0,1'b0,1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_clear(input logic [7:0] data);
    rd_en_i = 1'b1; step(1); rd_en_i = 1'b0;
    wr_en_i = 1'b1; wr_data_i = data; step(1);
    wr_en_i = 1'b0; wr_data_i = 8'hFF;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    check8("R3 flags", rd_data_o, 8'h00);
    check8("R3 req", {irq_req_o}, 8'h00);
    check8("R3 any", {7'b0, irq_any_o}, 8'h00);

    // R1 R2: sense-code table, all channels in the same mode
    for (int i = 0; i < 12; i++) begin
      rst_ni = 1'b0;
      sense_i = {8{VEC[i][4:3]}};
      irq_pin_i = {8{VEC[i][2]}};
      step(2);
      rst_ni = 1'b1;
      step(5);
      sw_clear(8'h00);
      irq_pin_i = {8{VEC[i][1]}};
      step(4);
      check8($sformatf("R1 R2 vec%0d flags", i), rd_data_o, {8{VEC[i][0]}});
    end

    // directed: all channels falling-edge
    rst_ni = 1'b0; sense_i = {8{2'b01}}; irq_pin_i = 8'hFF; step(2);
    rst_ni = 1'b1; step(3);

    // R5 / R4
    irq_pin_i[3] = 1'b0; step(4);
    check8("R2 ch3 set", rd_data_o, 8'h08);
    wr_en_i = 1'b1; wr_data_i = 8'h00; step(1); wr_en_i = 1'b0; wr_data_i = 8'hFF;
    check8("R5 zero write without read", rd_data_o, 8'h08);
    sw_clear(8'hFF);
    check8("R4 one write", rd_data_o, 8'h08);
    wr_en_i = 1'b1; wr_data_i = 8'h00; step(1); wr_en_i = 1'b0; wr_data_i = 8'hFF;
    check8("R5 armed zero write", rd_data_o, 8'h00);
    irq_pin_i[3] = 1'b1; step(3);

    // R7
    irq_pin_i[2] = 1'b0; step(4);
    ack_i = 8'h04; step(1); ack_i = 8'h00;
    check8("R7 edge ack", rd_data_o, 8'h00);
    irq_pin_i[2] = 1'b1; step(3);

    // R8
    irq_pin_i[1] = 1'b0; step(4);
    hold_i = 8'h02; ack_i = 8'h02; step(1); ack_i = 8'h00;
    check8("R8 hold blocks ack", rd_data_o, 8'h02);
    sw_clear(8'h00);
    check8("R8 software clear under hold", rd_data_o, 8'h00);
    hold_i = 8'h00; irq_pin_i[1] = 1'b1; step(3);

    // R6: channel 0 low level
    sense_i[1:0] = 2'b00;
    irq_pin_i[0] = 1'b0; step(4);
    check8("R6 level set", rd_data_o, 8'h01);
    ack_i = 8'h01; step(1); ack_i = 8'h00;
    check8("R6 ack while low", rd_data_o, 8'h01);
    irq_pin_i[0] = 1'b1; step(4);
    check8("R6 sticky after release", rd_data_o, 8'h01);
    ack_i = 8'h01; step(1); ack_i = 8'h00;
    check8("R6 ack while high", rd_data_o, 8'h00);
    sense_i[1:0] = 2'b01; step(1);

    // R9
    irq_pin_i = 8'h7E; step(4);
    check8("R9 flags", rd_data_o, 8'h81);
    irq_en_i = 8'h01; step(1);
    check8("R9 req masked", irq_req_o, 8'h01);
    check8("R9 any on", {7'b0, irq_any_o}, 8'h01);
    irq_en_i = 8'h00; step(1);
    check8("R9 any off", {7'b0, irq_any_o}, 8'h00);
    irq_en_i = 8'hFF;
    sw_clear(8'h00);
    irq_pin_i = 8'hFF; step(3);

    // R10: set and ack land on the same edge
    irq_pin_i[4] = 1'b0; step(2);
    ack_i = 8'h10; step(1); ack_i = 8'h00;
    check8("R10 set wins", rd_data_o, 8'h10);
    ack_i = 8'h10; step(1); ack_i = 8'h00;
    check8("R10 later ack", rd_data_o, 8'h00);
    irq_pin_i[4] = 1'b1; step(3);

    // R11: latency
    irq_pin_i[5] = 1'b0; step(2);
    check8("R11 not before third edge", rd_data_o, 8'h00);
    step(1);
    check8("R11 at third edge", rd_data_o, 8'h20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule